// File: doc/BRIEF.md
# 3x3 Weighted Neighbourhood Engine

This block runs one fixed-size neighbourhood reduction over a raster image. A host loads nine signed weights and picks one of three reductions through a small register-style write port. It then streams the image in one pixel at a time, with pixels unsigned and 16 bits wide, left to right and top to bottom. For every input position the engine forms the 3x3 window centred there and multiplies each window pixel by the weight at the same window position. The reduction is one of three: the sum of the nine products, the largest product, or the smallest product. The result is clamped to the pixel range and sent out in the same raster order.

Pixels that would lie outside the picture take the value of the nearest edge pixel. The engine holds the two previous rows in on-chip row stores, so each result leaves about one image row plus one pixel after its input. Once the final pixel of a frame is in, the engine steps through the remaining results by itself at one per clock, and it marks the last result of the frame. The image size defaults to 256 by 256 and is set by parameters.

Top module: `nbhd3x3_engine`

## Requirements
- R1: While reset is held, out_valid and out_last are low. After reset the nine weights are 0 except the centre weight, which is 1, and the reduction is the weighted sum, so an unconfigured frame reproduces its input.
- R2: A write with cfg_addr 0 to 8 stores cfg_wdata as a signed weight for one window position, numbered row-major (0 top-left, 4 centre, 8 bottom-right). A write with cfg_addr 9 stores the reduction code from cfg_wdata[1:0]: 00 weighted sum, 01 largest product, 1x smallest product. Writes to addresses 10 to 15 change nothing.
- R3: In sum mode the result is the sum of the nine products (unsigned pixel times signed weight) at full precision, clamped to 0..65535.
- R4: In largest and smallest mode the result is the largest or smallest of the nine signed products, clamped to 0..65535.
- R5: A window position above, below, left or right of the image uses the nearest pixel on the image edge, corners included.
- R6: Each frame yields exactly IMG_W*IMG_H results in raster order. out_last is high with the last one only, and no result leaves outside a frame.
- R7: The result for pixel k appears on out_valid one clock after the rising edge that accepts pixel k+IMG_W+1. After the final pixel is accepted, the engine takes one step per clock on its own, as if a pixel were accepted on each of the next IMG_W+1 edges.
- R8: Weights and reduction code are captured when a frame's first pixel is accepted. Writes made during a frame take effect from the next frame.
- R9: in_valid pulses that arrive while the engine steps through the end of a frame are dropped and enter no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address: 0-8 weights, 9 reduction code |
| cfg_wdata | input | WGT_W | Configuration write data |
| in_valid | input | 1 | Input pixel is present this cycle |
| in_pixel | input | PIX_W | Input pixel, unsigned |
| out_valid | output | 1 | Result is present this cycle |
| out_data | output | PIX_W | Clamped result |
| out_last | output | 1 | Marks the final result of a frame |

## Verification
Result k depends on pixel k+IMG_W+1. Each result is due on the clock after the edge that accepts that pixel. For the trailing IMG_W+1 results, it is due on the clock after the matching self-timed step that follows the final pixel. The bench records the edge at which it hands over each pixel. It derives the trailing steps by counting on from the final one, and it compares the arrival cycle of every result with that due cycle. Data are compared against a window model in the bench that clamps indices at the image edges. Inputs are driven and outputs read on falling edges, so each check lands one half cycle after the register that produced it has loaded.

// File: rtl/nbhd3x3_engine.sv
module nbhd3x3_engine #(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int PIX_W = 16,
  parameter int WGT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [WGT_W-1:0] cfg_wdata,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_last
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H + 2);
  localparam int PW = PIX_W + WGT_W + 1;
  localparam int AW = PW + 4;
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [CW-1:0] COL_ONE  = CW'(1);
  localparam logic [RW-1:0] ROW_ONE  = RW'(1);
  localparam logic [RW-1:0] ROW_TWO  = RW'(2);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
  localparam logic [RW-1:0] ROW_PAD  = RW'(IMG_H);
  localparam logic [RW-1:0] ROW_END  = RW'(IMG_H + 1);
  localparam logic signed [AW-1:0] PIX_MAX = AW'((1 << PIX_W) - 1);

  function automatic logic [PIX_W-1:0] clip(input logic signed [AW-1:0] v);
    if (v[AW-1]) return '0;
    if (v > PIX_MAX) return '1;
    return v[PIX_W-1:0];
  endfunction

  // sequencing: one step per accepted pixel, then self-timed tail
  logic          busy, flush;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          adv, start, fin;

  assign adv   = flush | in_valid;
  assign start = in_valid & ~busy;
  assign fin   = adv & (row == ROW_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      flush <= 1'b0;
      col   <= '0;
      row   <= '0;
    end else if (adv) begin
      if (fin) begin
        busy  <= 1'b0;
        flush <= 1'b0;
        col   <= '0;
        row   <= '0;
      end else begin
        busy <= 1'b1;
        if (row == ROW_LAST && col == COL_LAST) flush <= 1'b1;
        if (col == COL_LAST) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  // configuration: shadow set written by host, active set frozen per frame
  logic signed [WGT_W-1:0] sh_w  [9];
  logic signed [WGT_W-1:0] act_w [9];
  logic [1:0]              sh_op, act_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) begin
        sh_w[i]  <= (i == 4) ? WGT_W'(1) : '0;
        act_w[i] <= (i == 4) ? WGT_W'(1) : '0;
      end
      sh_op  <= 2'b00;
      act_op <= 2'b00;
    end else begin
      if (cfg_we) begin
        if (cfg_addr < 4'd9) sh_w[cfg_addr] <= cfg_wdata;
        else if (cfg_addr == 4'd9) sh_op <= cfg_wdata[1:0];
      end
      if (start) begin
        act_w  <= sh_w;
        act_op <= sh_op;
      end
    end
  end

  // row stores and window columns with vertical edge replication
  logic [PIX_W-1:0] lb_a [IMG_W];
  logic [PIX_W-1:0] lb_b [IMG_W];
  logic [PIX_W-1:0] col_in [3];
  logic [PIX_W-1:0] win [9];

  assign col_in[1] = lb_a[col];
  assign col_in[0] = (row == ROW_ONE) ? lb_a[col] : lb_b[col];
  assign col_in[2] = (row >= ROW_PAD) ? lb_a[col] : in_pixel;

  always_ff @(posedge clk) begin
    if (adv) begin
      lb_b[col] <= lb_a[col];
      lb_a[col] <= in_pixel;
      for (int r = 0; r < 3; r++) begin
        win[3*r]   <= win[3*r+1];
        win[3*r+1] <= win[3*r+2];
        win[3*r+2] <= col_in[r];
      end
    end
  end

  logic st_valid, st_lrep, st_rrep, st_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_lrep  <= 1'b0;
      st_rrep  <= 1'b0;
      st_last  <= 1'b0;
    end else begin
      st_valid <= adv && ((row >= ROW_TWO) || (row == ROW_ONE && col != '0));
      st_lrep  <= col == COL_ONE;
      st_rrep  <= col == '0;
      st_last  <= fin;
    end
  end

  // taps with horizontal edge replication, then the reduction
  logic [PIX_W-1:0]        tap  [9];
  logic signed [PW-1:0]    prod [9];
  logic signed [PW-1:0]    pmax, pmin;
  logic signed [AW-1:0]    acc, pick;

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      tap[3*r]   = st_lrep ? win[3*r+1] : win[3*r];
      tap[3*r+1] = win[3*r+1];
      tap[3*r+2] = st_rrep ? win[3*r+1] : win[3*r+2];
    end
    for (int i = 0; i < 9; i++)
      prod[i] = PW'($signed({1'b0, tap[i]})) * PW'(act_w[i]);
    acc  = '0;
    pmax = prod[0];
    pmin = prod[0];
    for (int i = 0; i < 9; i++) begin
      acc = acc + AW'(prod[i]);
      if (prod[i] > pmax) pmax = prod[i];
      if (prod[i] < pmin) pmin = prod[i];
    end
    if (act_op[1])      pick = AW'(pmin);
    else if (act_op[0]) pick = AW'(pmax);
    else                pick = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= st_valid;
      out_last  <= st_valid & st_last;
      if (st_valid) out_data <= clip(pick);
    end
  end
endmodule

// File: rtl/nbhd3x3_engine_chk.sv
module nbhd3x3_engine_chk #(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_last,
  input logic [PIX_W-1:0] out_data,
  input logic             busy,
  input logic [1:0]       act_op
);
  localparam int FRAME_N = IMG_W * IMG_H;

  int unsigned seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 0;
    else if (out_valid) seen <= out_last ? 0 : seen + 1;
  end

  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r6_frame_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (seen == FRAME_N - 1));

  a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r8_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_op));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_reset: assert (!out_valid && !out_last);
    end
  end
endmodule

bind nbhd3x3_engine nbhd3x3_engine_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_last(out_last),
  .out_data(out_data), .busy(busy), .act_op(act_op)
);

// File: tb/nbhd3x3_engine_tb.sv
module nbhd3x3_engine_tb;
  localparam int W = 5;
  localparam int H = 4;
  localparam int N = W * H;

  // entry: {op[1:0], pattern[1:0], w0..w8}
  localparam logic [75:0] TBL [7] = '{
    {2'b00, 2'd0, {9{8'd1}}},
    {2'b00, 2'd1, {4{8'hFF}}, 8'd8, {4{8'hFF}}},
    {2'b01, 2'd1, {9{8'd1}}},
    {2'b10, 2'd1, {9{8'd1}}},
    {2'b01, 2'd0, 8'd2, 8'hFF, 8'd3, 8'd0, 8'd1, 8'hFE, 8'd1, 8'd1, 8'hFF},
    {2'b00, 2'd2, {9{8'd127}}},
    {2'b11, 2'd1, 8'hFF, 8'd2, 8'hFF, 8'd1, 8'hFD, 8'd1, 8'd4, 8'hFF, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, in_valid = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] in_pixel = '0;
  logic        out_valid, out_last;
  logic [15:0] out_data;

  always #5 clk = ~clk;

  nbhd3x3_engine #(.IMG_W(W), .IMG_H(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0, errors = 0, cyc = 0;
  int bw [9];
  int bop;
  int fw [9];
  int fop;
  int img [N];
  int expv [N];
  int acc_t [N];
  int out_cnt = 0;
  bit frame_on = 1'b0;
  string tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int n);
    if (v < 0) return 0;
    if (v >= n) return n - 1;
    return v;
  endfunction

  function automatic int pix(input int pat, input int r, input int c);
    longint unsigned h;
    case (pat)
      0: return r * 40 + c * 3 + 1;
      1: begin
        h = longint'(r * 37 + c * 11 + 5) * 64'd2654435761;
        return int'((h >> 13) & 64'hFFFF);
      end
      default: return 65535 - r * 7 - c;
    endcase
  endfunction

  function automatic int model(input int r, input int c);
    longint s, mx, mn, p, v;
    s = 0; mx = 0; mn = 0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        p = longint'(fw[(dr + 1) * 3 + dc + 1]) *
            longint'(img[clampi(r + dr, H) * W + clampi(c + dc, W)]);
        if (dr == -1 && dc == -1) begin mx = p; mn = p; end
        if (p > mx) mx = p;
        if (p < mn) mn = p;
        s += p;
      end
    end
    if (fop >= 2) v = mn;
    else if (fop == 1) v = mx;
    else v = s;
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return int'(v);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 9) bw[a] = int'($signed(8'(d)));
    else if (a == 9) bop = d & 3;
  endtask

  task automatic run_frame(input int pat, input int gap, input bit junk, input bit midcfg, input string req);
    tag = req;
    fw = bw; fop = bop;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r * W + c] = pix(pat, r, c);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) expv[r * W + c] = model(r, c);
    out_cnt = 0;
    frame_on = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_pixel = 16'(img[k]); acc_t[k] = cyc + 1;
      cfg_we = midcfg && k == 7; cfg_addr = 4'd4; cfg_wdata = 8'd3;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
      end
    end
    if (midcfg) bw[4] = 3;
    @(negedge clk);
    cfg_we = 1'b0;
    if (junk) begin
      in_valid = 1'b1; in_pixel = 16'hBEEF;
      repeat (W - 1) @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (W + 6) @(negedge clk);
    chk(out_cnt == N, "R6", "results per frame", out_cnt, N);
    frame_on = 1'b0;
  endtask

  always @(negedge clk) begin
    int k, j, due;
    if (rst_n && out_valid) begin
      if (!frame_on || out_cnt >= N) begin
        chk(1'b0, "R6", "result outside frame", out_cnt, N);
      end else begin
        k = out_cnt;
        j = k + W + 1;
        due = (j < N ? acc_t[j] : acc_t[N - 1] + (j - N + 1)) + 1;
        if (k / W == 0 || k / W == H - 1 || k % W == 0 || k % W == W - 1)
          chk(out_data == 16'(expv[k]), "R5", {tag, " border data"}, int'(out_data), expv[k]);
        else
          chk(out_data == 16'(expv[k]), tag, "data", int'(out_data), expv[k]);
        chk(cyc == due, "R7", "result cycle", cyc, due);
        chk(out_last == (k == N - 1), "R6", "last marker", int'(out_last), int'(k == N - 1));
      end
      out_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) bw[i] = (i == 4) ? 1 : 0;
    bop = 0;
    repeat (3) begin
      @(negedge clk);
      chk(!out_valid && !out_last, "R1", "outputs in reset", int'(out_valid | out_last), 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: default config passes the image through
    run_frame(0, 0, 1'b0, 1'b0, "R1");

    for (int t = 0; t < 7; t++) begin
      for (int i = 0; i < 9; i++) wr(i, int'(TBL[t][71 - 8 * i -: 8]));
      wr(9, int'(TBL[t][75:74]));
      run_frame(int'(TBL[t][73:72]), 0, 1'b0, 1'b0, (TBL[t][75:74] == 2'b00) ? "R3" : "R4");
    end

    // R2: op 11 is smallest, unused addresses leave everything as is
    wr(10, 8'h55);
    wr(12, 8'h7F);
    wr(15, 8'h01);
    run_frame(0, 0, 1'b0, 1'b0, "R2");

    // R8: mid-frame weight write waits for the next frame
    wr(9, 0);
    for (int i = 0; i < 9; i++) wr(i, (i % 2 == 0) ? 1 : 2);
    run_frame(1, 0, 1'b0, 1'b1, "R8");
    run_frame(1, 0, 1'b0, 1'b0, "R8");

    // R9: pulses during the tail are dropped
    run_frame(2, 0, 1'b1, 1'b0, "R9");
    run_frame(0, 0, 1'b0, 1'b0, "R9");

    // R7: idle gaps between pixels
    wr(9, 1);
    run_frame(1, 2, 1'b0, 1'b0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule